// File: doc/BRIEF.md
# Serial Clock-Output Enable Controller

This block receives SMBus block writes from a host over a two-wire serial bus and turns the received bytes into per-output gates for an 18-way clock fanout. A fast system clock oversamples SCL and SDA. From those samples the block finds START and STOP conditions and rising and falling SCL edges. It then walks the transfer byte by byte: slave address, command code, byte count, and data. It pulls SDA low to acknowledge each accepted byte and never holds SCL.

Data bytes fill an enable bank in ascending order, and there is no index. Each enable bit decides whether its output copies the reference clock or stays LOW. A separate output-enable pin overrides the whole bank and releases every output. The block is write-only. It does not answer reads or general calls.

Top module: `clkgate_smbus_ctrl`

## Requirements
- R1: The block acknowledges only the address byte 1101001 followed by R/W = 0 (byte value 0xD2). For any other address byte, and for any read request, it leaves SDA released and ignores all bus activity until the next START.
- R2: After an accepted address byte, the block pulls SDA low during the ninth SCL clock of the command code, the byte count and every data byte. The SDA pull starts and ends only while SCL is low.
- R3: The values of the command code and the byte count are ignored, including a count of zero. Only the number of data bytes actually sent decides which registers are written.
- R4: Data bytes load the enable bank in ascending order, starting from the first register after every new address phase. A STOP after any complete byte keeps all the bytes written so far.
- R5: Data bytes past the third register are acknowledged and discarded. The enables are left unchanged.
- R6: Bits arrive MSB first. Data byte 0 bit k enables output k. Data byte 1 bit k enables output 8+k. Data byte 2 bit 7 enables output 17 and bit 6 enables output 16. Bits 5..0 of data byte 2 have no effect.
- R7: After reset every enable bit is 1, so all 18 outputs are active.
- R8: With OE high, an output whose enable is 1 equals the reference clock, and an output whose enable is 0 is held LOW.
- R9: With OE low, `out_drv` is 0 (all outputs high-impedance) and every `clk_out` bit is 0, whatever the enables hold.
- R10: A START or repeated START, even in the middle of a byte, aborts the current byte and restarts address matching. A STOP returns the block to idle.
- R11: A data byte changes the enables only once its eighth bit has been received. A partial byte cut off by START or STOP changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| ref_clk_i | input | 1 | Reference clock that is fanned out |
| oe_i | input | 1 | Active-high output enable for the whole bank |
| clk_out | output | 18 | Gated clock outputs |
| out_drv | output | 1 | 1 = outputs driven, 0 = outputs high-impedance |

## Verification
On every cycle, the assertions check the following: the acknowledge pull changes only while SCL is low; an ignored transfer never acknowledges; START and STOP put the receiver into the right state; the bit counter stays in range; and the enable bank holds its value unless a completed data byte is written. Other behaviours need whole bus scenarios in the bench to show them. These are the address and R/W decoding, the ascending byte order, the discarding of surplus bytes, the mapping of byte 2 to the top two outputs, a repeated START in the middle of a byte, and the way OE overrides the enables.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_ADDR   = 3'd1,
        RX_CMD    = 3'd2,
        RX_CNT    = 3'd3,
        RX_DATA   = 3'd4,
        RX_IGNORE = 3'd5
    } rx_st_e;

    localparam logic [6:0] DEF_SLV_ADDR = 7'b1101001;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [1:0] scl_sync;
        logic [1:0] sda_sync;
        logic       scl_prev;
        logic       sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[0], sda_i};
        smp_d.scl_prev = smp_q.scl_sync[1];
        smp_d.sda_prev = smp_q.sda_sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_s     = smp_q.scl_sync[1];
    assign sda_s     = smp_q.sda_sync[1];
    assign scl_rise  = scl_s & ~smp_q.scl_prev;
    assign scl_fall  = ~scl_s & smp_q.scl_prev;
    assign start_det = scl_s & smp_q.scl_prev & smp_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & smp_q.scl_prev & ~smp_q.sda_prev & sda_s;
endmodule

// File: rtl/smbus_rx.sv
module smbus_rx
    import clkgate_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = DEF_SLV_ADDR,
    parameter int         NUM_REG  = 3,
    localparam int        IW       = $clog2(NUM_REG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          ack_o,
    output logic          wr_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [7:0]    wr_data_o
);
    typedef struct packed {
        rx_st_e        st;
        logic [3:0]    bc;
        logic [7:0]    sh;
        logic          ack;
        logic          pend;
        logic [IW-1:0] idx;
    } rx_t;

    rx_t        rx_d, rx_q;
    logic       wr;
    logic [7:0] byte_w;

    always_comb begin
        rx_d   = rx_q;
        wr     = 1'b0;
        byte_w = {rx_q.sh[6:0], sda_s};
        if (stop_det) begin
            rx_d.st  = RX_IDLE;
            rx_d.bc  = 4'd0;
            rx_d.ack = 1'b0;
        end else if (start_det) begin
            rx_d.st  = RX_ADDR;
            rx_d.bc  = 4'd0;
            rx_d.ack = 1'b0;
        end else if (rx_q.st inside {RX_ADDR, RX_CMD, RX_CNT, RX_DATA}) begin
            if (scl_rise && rx_q.bc < 4'd8) begin
                rx_d.sh = byte_w;
                rx_d.bc = rx_q.bc + 4'd1;
                if (rx_q.bc == 4'd7) begin
                    rx_d.pend = 1'b1;
                    case (rx_q.st)
                        RX_ADDR: begin
                            if (byte_w == {SLV_ADDR, 1'b0}) rx_d.st = RX_CMD;
                            else begin
                                rx_d.st   = RX_IGNORE;
                                rx_d.pend = 1'b0;
                            end
                        end
                        RX_CMD: rx_d.st = RX_CNT;
                        RX_CNT: begin
                            rx_d.st  = RX_DATA;
                            rx_d.idx = '0;
                        end
                        default: begin
                            if (rx_q.idx < IW'(NUM_REG)) begin
                                wr       = 1'b1;
                                rx_d.idx = rx_q.idx + 1'b1;
                            end
                        end
                    endcase
                end
            end else if (scl_fall && rx_q.bc == 4'd8) begin
                rx_d.bc  = 4'd9;
                rx_d.ack = rx_q.pend;
            end else if (scl_fall && rx_q.bc == 4'd9) begin
                rx_d.bc  = 4'd0;
                rx_d.ack = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '{st: RX_IDLE, bc: 4'd0, sh: 8'd0, ack: 1'b0, pend: 1'b0, idx: '0};
        else        rx_q <= rx_d;
    end

    assign ack_o     = rx_q.ack;
    assign wr_o      = wr;
    assign wr_idx_o  = rx_q.idx;
    assign wr_data_o = byte_w;

    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_q.ack) |-> !scl_s); // R2
    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_q.ack) && !start_det && !stop_det |-> !scl_s); // R2
    AST_IGNORE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) rx_q.st == RX_IGNORE |-> !rx_q.ack); // R1
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n) start_det && !stop_det |=> rx_q.st == RX_ADDR && rx_q.bc == 4'd0 && !rx_q.ack); // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> rx_q.st == RX_IDLE && !rx_q.ack); // R10
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rx_q.bc <= 4'd9); // R11
endmodule

// File: rtl/enable_bank.sv
module enable_bank #(
    parameter int  NUM_OUT = 18,
    localparam int NUM_REG = (NUM_OUT + 7) / 8,
    localparam int IW      = $clog2(NUM_REG + 1),
    localparam int PAD     = NUM_REG * 8 - NUM_OUT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [IW-1:0]      idx_i,
    input  logic [7:0]         data_i,
    output logic [NUM_OUT-1:0] en_o
);
    logic [NUM_OUT-1:0] en_d, en_q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        localparam int REG_I = i / 8;
        localparam int POS_I = (REG_I == NUM_REG - 1) ? (i % 8) + PAD : (i % 8);
        assign en_d[i] = (wr_i && idx_i == IW'(REG_I)) ? data_i[POS_I] : en_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_i |=> $stable(en_q)); // R11
endmodule

// File: rtl/clkgate_smbus_ctrl.sv
module clkgate_smbus_ctrl
    import clkgate_pkg::*;
#(
    parameter int         NUM_OUT  = 18,
    parameter logic [6:0] SLV_ADDR = DEF_SLV_ADDR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull,
    input  logic               ref_clk_i,
    input  logic               oe_i,
    output logic [NUM_OUT-1:0] clk_out,
    output logic               out_drv
);
    localparam int NUM_REG = (NUM_OUT + 7) / 8;
    localparam int IW      = $clog2(NUM_REG + 1);

    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic               wr;
    logic [IW-1:0]      wr_idx;
    logic [7:0]         wr_data;
    logic [NUM_OUT-1:0] en;

    bus_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smbus_rx #(.SLV_ADDR(SLV_ADDR), .NUM_REG(NUM_REG)) u_rx (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .ack_o(sda_pull), .wr_o(wr), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data)
    );

    enable_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .idx_i(wr_idx), .data_i(wr_data),
        .en_o(en)
    );

    assign out_drv = oe_i;
    assign clk_out = oe_i ? (en & {NUM_OUT{ref_clk_i}}) : '0;
endmodule

// File: tb/clkgate_smbus_ctrl_bench.sv
module clkgate_smbus_ctrl_bench;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        ref_clk = 1'b0;
    logic        oe = 1'b1;
    logic        sda_pull;
    logic        sda_line;
    logic [17:0] clk_out;
    logic        out_drv;
    logic [17:0] exp_en = '1;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    clkgate_smbus_ctrl u_clkgate_smbus_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .ref_clk_i(ref_clk), .oe_i(oe),
        .clk_out(clk_out), .out_drv(out_drv)
    );

    function automatic logic [17:0] apply_byte(logic [17:0] cur, int k, logic [7:0] b);
        logic [17:0] r = cur;
        if (k == 0) r[7:0] = b;
        else if (k == 1) r[15:8] = b;
        else if (k == 2) r[17:16] = b[7:6];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_h(H);
        scl = 1'b1;   wait_h(H);
        sda_m = 1'b0; wait_h(H);
        scl = 1'b0;   wait_h(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_h(H);
        scl = 1'b1;   wait_h(H);
        sda_m = 1'b1; wait_h(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_h(H);
        scl = 1'b1; wait_h(H);
        scl = 1'b0; wait_h(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wait_h(H);
        scl = 1'b1; wait_h(H / 2);
        acked = !sda_line;
        wait_h(H / 2);
        scl = 1'b0; wait_h(2);
    endtask

    task automatic check_en(input logic [17:0] exp, input string req);
        ref_clk = 1'b1; #1;
        check(clk_out == exp && out_drv, req, {14'd0, clk_out}, {14'd0, exp});
        ref_clk = 1'b0; #1;
        check(clk_out == 18'd0, req, {14'd0, clk_out}, 32'd0);
    endtask

    task automatic block_write(input logic [7:0] cmd, input logic [7:0] cnt,
                               input logic [7:0] d [8], input int n, input string req);
        bit a;
        bit all_ok = 1'b1;
        bus_start();
        put_byte(8'hD2, a); all_ok &= a;
        put_byte(cmd, a);   all_ok &= a;
        put_byte(cnt, a);   all_ok &= a;
        for (int k = 0; k < n; k++) begin
            put_byte(d[k], a); all_ok &= a;
            exp_en = apply_byte(exp_en, k, d[k]);
        end
        bus_stop();
        check(all_ok, req, {31'd0, all_ok}, 32'd1);
        check_en(exp_en, req);
    endtask

    initial begin
        wait_h(200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [8];
        bit a;
        void'($urandom(32'd4242));
        wait_h(4); rst_n = 1'b1; wait_h(4);

        // R7 reset state, R8 follow reference
        check(!sda_pull, "R7", {31'd0, sda_pull}, 32'd0);
        check_en(18'h3FFFF, "R7 R8");

        // R4 R6 full write, R2 acks
        d = '{8'hA5, 8'h3C, 8'h80, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        block_write(8'h00, 8'd3, d, 3, "R2 R4 R6");

        // R6 reserved bits of byte 2 no effect
        d = '{8'hA5, 8'h3C, 8'h7F, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        block_write(8'h00, 8'd3, d, 3, "R6 byte2");

        // R4 stop after one byte, R3 count value ignored (zero)
        d = '{8'h0F, 8'h00, 8'h00, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        block_write(8'h77, 8'd0, d, 1, "R3 R4");

        // R5 extra bytes acked and discarded
        d = '{8'hFF, 8'hFF, 8'hC0, 8'h12, 8'h34, 8'h56, 8'h0, 8'h0};
        block_write(8'h00, 8'd32, d, 6, "R5");

        // R1 wrong address: NACK and ignored
        bus_start();
        put_byte(8'hD4, a);
        check(!a, "R1 addr", {31'd0, a}, 32'd0);
        put_byte(8'h00, a); put_byte(8'h01, a); put_byte(8'h00, a);
        check(!a, "R1 ignored", {31'd0, a}, 32'd0);
        bus_stop();
        check_en(exp_en, "R1");

        // R1 read request NACK
        bus_start();
        put_byte(8'hD3, a);
        check(!a, "R1 read", {31'd0, a}, 32'd0);
        bus_stop();
        check_en(exp_en, "R1 read");

        // R10 R11 repeated START mid data byte
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h02, a);
        put_byte(8'h5A, a);
        exp_en = apply_byte(exp_en, 0, 8'h5A);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        check_en(exp_en, "R11 partial");
        bus_start();
        put_byte(8'hD2, a);
        check(a, "R10 readdress", {31'd0, a}, 32'd1);
        put_byte(8'h00, a); put_byte(8'h01, a); put_byte(8'hE1, a);
        exp_en = apply_byte(exp_en, 0, 8'hE1);
        bus_stop();
        check_en(exp_en, "R10 R4");

        // R10 R11 STOP mid byte
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h01, a);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        scl = 1'b0; bus_stop();
        check_en(exp_en, "R10 R11 stop");

        // R9 OE overrides
        oe = 1'b0; ref_clk = 1'b1; #1;
        check(!out_drv && clk_out == 18'd0, "R9", {13'd0, out_drv, clk_out}, 32'd0);
        ref_clk = 1'b0; oe = 1'b1; #1;

        // random transfers
        for (int t = 0; t < 25; t++) begin
            int n = 1 + int'($urandom_range(0, 4));
            for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
            block_write(8'($urandom), 8'($urandom_range(1, 32)), d, n, "R4 R6 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule